// File: doc/BRIEF.md
# GPIO Pin Bank with Sleep Override

This block is one bank of 32 general purpose I/O pins, controlled over a simple register bus. Each pin can be a software-driven GPIO, or it can be handed to one of three peripheral functions, called A, B and C. Software owns a few registers: an output data latch, a direction word, a pull-off word, two function-select words and a sleep-keep word. The data latch and the direction word each have their own write-one-to-set and write-one-to-clear addresses. Because of this, a driver can change single pins without a read-modify-write.

For every pin, the bank drives the pad's output value, output enable, pull enable and pull direction. It takes each value either from its own registers or from the selected peripheral. The pull direction follows the pin's data latch bit, so choosing up or down also changes the latched output value. Pad inputs pass through a synchronizer. The synchronized levels can be read back, and they also feed a separate interrupt block.

While the `sleep_force` input is high, every pin whose sleep-keep bit is 0 is switched to GPIO mode. Its select words are ignored during that time. When `sleep_force` falls, every pin returns to its selected function.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register reads zero. Every pin is then a GPIO input (`pad_oe`=0) with its pull enabled (`pad_pull_en`=1) and pointing down (`pad_pull_up`=0), and the effective select outputs are 0.
- R2: A write to address 2 sets the data latch bits given as 1. A write to address 3 clears them. Zero bits leave the latch unchanged. Address 1 reads and fully writes the latch. Addresses 2 and 3 read as zero.
- R3: A write to address 5 sets direction bits and a write to address 6 clears them. Address 4 reads and fully writes the direction word. In GPIO mode a direction bit of 1 drives `pad_oe` high and `pad_out` from the data latch.
- R4: The effective function code of a pin is {bit of word at address 9, bit of word at address 8}: 00 GPIO, 01 function A, 10 function B, 11 function C. The pad's out and oe come from the matching peripheral pair. `pin_sel_hi`/`pin_sel_lo` show the effective code.
- R5: A 1 at address 7 (pull-off) disables the pin's pull. The pull is also disabled whenever the pad is driven (`pad_oe`=1), in any function.
- R6: `pad_pull_up` equals the pin's data latch bit.
- R7: While `sleep_force`=1, a pin whose bit at address 10 (sleep-keep) is 0 has effective code 00 and behaves as GPIO. A pin whose keep bit is 1 keeps its selected function.
- R8: When `sleep_force` returns to 0, every pin's effective code again equals its select bits, with no register write needed.
- R9: `pin_level` equals `pad_in` delayed by two clock edges. Address 0 reads `pin_level` and ignores writes.
- R10: A read issued with `bus_valid`=1, `bus_write`=0 returns data on `bus_rdata` after the next edge. `bus_rdata` is zero in any cycle after no read. Addresses 11 to 31 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pad_in | input | 32 | Raw pad input levels |
| sleep_force | input | 1 | Sleep override request |
| alt_a_out | input | 32 | Function A output values |
| alt_a_oe | input | 32 | Function A output enables |
| alt_b_out | input | 32 | Function B output values |
| alt_b_oe | input | 32 | Function B output enables |
| alt_c_out | input | 32 | Function C output values |
| alt_c_oe | input | 32 | Function C output enables |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pull_en | output | 32 | Pull resistor enable |
| pad_pull_up | output | 32 | Pull direction, 1 = up |
| pin_sel_lo | output | 32 | Effective function code, low bit |
| pin_sel_hi | output | 32 | Effective function code, high bit |
| pin_level | output | 32 | Synchronized pad inputs |

## Verification
The select words are swept with rotating patterns so that all four codes appear on many pins at once. The three peripheral sources carry distinct out and oe patterns, so a pin that picks the wrong source is caught. The sleep-keep word is swept together with `sleep_force` high and then low. This separates pins that must drop to GPIO from pins that must keep their function, and it shows the release happens with no rewrite. Set and clear writes use overlapping masks, which shows that zero bits leave state alone. Pad input steps are read after the synchronizer delay.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_LEVEL   = 5'd0;
    localparam logic [ADDR_W-1:0] A_DOUT    = 5'd1;
    localparam logic [ADDR_W-1:0] A_DSET    = 5'd2;
    localparam logic [ADDR_W-1:0] A_DCLR    = 5'd3;
    localparam logic [ADDR_W-1:0] A_DIR     = 5'd4;
    localparam logic [ADDR_W-1:0] A_DIRSET  = 5'd5;
    localparam logic [ADDR_W-1:0] A_DIRCLR  = 5'd6;
    localparam logic [ADDR_W-1:0] A_PULLOFF = 5'd7;
    localparam logic [ADDR_W-1:0] A_SELLO   = 5'd8;
    localparam logic [ADDR_W-1:0] A_SELHI   = 5'd9;
    localparam logic [ADDR_W-1:0] A_KEEP    = 5'd10;

    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_A    = 2'b01,
        FN_B    = 2'b10,
        FN_C    = 2'b11
    } func_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = raw_i;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
        end
    end

    assign sync_o = stg_q[LAST];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  level_i,
    output logic [NPINS-1:0]  bus_rdata,
    output logic [NPINS-1:0]  dout_o,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  pull_off_o,
    output logic [NPINS-1:0]  sel_lo_o,
    output logic [NPINS-1:0]  sel_hi_o,
    output logic [NPINS-1:0]  keep_o
);
    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] pull_off;
        logic [NPINS-1:0] sel_lo;
        logic [NPINS-1:0] sel_hi;
        logic [NPINS-1:0] keep;
        logic [NPINS-1:0] rdata;
    } state_t;

    state_t st_d, st_q;
    logic   wr_en, rd_en;

    assign wr_en = bus_valid &  bus_write;
    assign rd_en = bus_valid & ~bus_write;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_en) begin
            unique case (bus_addr)
                A_DOUT:    st_d.dout     = bus_wdata;
                A_DSET:    st_d.dout     = st_q.dout | bus_wdata;
                A_DCLR:    st_d.dout     = st_q.dout & ~bus_wdata;
                A_DIR:     st_d.dir      = bus_wdata;
                A_DIRSET:  st_d.dir      = st_q.dir | bus_wdata;
                A_DIRCLR:  st_d.dir      = st_q.dir & ~bus_wdata;
                A_PULLOFF: st_d.pull_off = bus_wdata;
                A_SELLO:   st_d.sel_lo   = bus_wdata;
                A_SELHI:   st_d.sel_hi   = bus_wdata;
                A_KEEP:    st_d.keep     = bus_wdata;
                default:   ;
            endcase
        end
        if (rd_en) begin
            unique case (bus_addr)
                A_LEVEL:   st_d.rdata = level_i;
                A_DOUT:    st_d.rdata = st_q.dout;
                A_DIR:     st_d.rdata = st_q.dir;
                A_PULLOFF: st_d.rdata = st_q.pull_off;
                A_SELLO:   st_d.rdata = st_q.sel_lo;
                A_SELHI:   st_d.rdata = st_q.sel_hi;
                A_KEEP:    st_d.rdata = st_q.keep;
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign dout_o     = st_q.dout;
    assign dir_o      = st_q.dir;
    assign pull_off_o = st_q.pull_off;
    assign sel_lo_o   = st_q.sel_lo;
    assign sel_hi_o   = st_q.sel_hi;
    assign keep_o     = st_q.keep;
endmodule

// File: rtl/pinbank_mux.sv
module pinbank_mux
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             sleep_force,
    input  logic [NPINS-1:0] dout_i,
    input  logic [NPINS-1:0] dir_i,
    input  logic [NPINS-1:0] pull_off_i,
    input  logic [NPINS-1:0] sel_lo_i,
    input  logic [NPINS-1:0] sel_hi_i,
    input  logic [NPINS-1:0] keep_i,
    input  logic [NPINS-1:0] a_out_i,
    input  logic [NPINS-1:0] a_oe_i,
    input  logic [NPINS-1:0] b_out_i,
    input  logic [NPINS-1:0] b_oe_i,
    input  logic [NPINS-1:0] c_out_i,
    input  logic [NPINS-1:0] c_oe_i,
    output logic [NPINS-1:0] pad_out_o,
    output logic [NPINS-1:0] pad_oe_o,
    output logic [NPINS-1:0] pull_en_o,
    output logic [NPINS-1:0] pull_up_o,
    output logic [NPINS-1:0] eff_lo_o,
    output logic [NPINS-1:0] eff_hi_o
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic  forced;
        func_e code;
        logic  drv_out, drv_oe;

        assign forced = sleep_force & ~keep_i[i];
        assign code   = forced ? FN_GPIO : func_e'({sel_hi_i[i], sel_lo_i[i]});

        always_comb begin
            unique case (code)
                FN_A:    begin drv_out = a_out_i[i]; drv_oe = a_oe_i[i]; end
                FN_B:    begin drv_out = b_out_i[i]; drv_oe = b_oe_i[i]; end
                FN_C:    begin drv_out = c_out_i[i]; drv_oe = c_oe_i[i]; end
                default: begin drv_out = dout_i[i];  drv_oe = dir_i[i];  end
            endcase
        end

        assign pad_out_o[i] = drv_out;
        assign pad_oe_o[i]  = drv_oe;
        assign pull_en_o[i] = ~pull_off_i[i] & ~drv_oe;
        assign pull_up_o[i] = dout_i[i];
        assign eff_lo_o[i]  = code[0];
        assign eff_hi_o[i]  = code[1];
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    input  logic              sleep_force,
    input  logic [NPINS-1:0]  alt_a_out,
    input  logic [NPINS-1:0]  alt_a_oe,
    input  logic [NPINS-1:0]  alt_b_out,
    input  logic [NPINS-1:0]  alt_b_oe,
    input  logic [NPINS-1:0]  alt_c_out,
    input  logic [NPINS-1:0]  alt_c_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pull_en,
    output logic [NPINS-1:0]  pad_pull_up,
    output logic [NPINS-1:0]  pin_sel_lo,
    output logic [NPINS-1:0]  pin_sel_hi,
    output logic [NPINS-1:0]  pin_level
);
    logic [NPINS-1:0] dout_w, dir_w, pull_off_w, sel_lo_w, sel_hi_w, keep_w;

    pinbank_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (pin_level)
    );

    pinbank_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .level_i    (pin_level),
        .bus_rdata  (bus_rdata),
        .dout_o     (dout_w),
        .dir_o      (dir_w),
        .pull_off_o (pull_off_w),
        .sel_lo_o   (sel_lo_w),
        .sel_hi_o   (sel_hi_w),
        .keep_o     (keep_w)
    );

    pinbank_mux #(.NPINS(NPINS)) u_mux (
        .sleep_force (sleep_force),
        .dout_i      (dout_w),
        .dir_i       (dir_w),
        .pull_off_i  (pull_off_w),
        .sel_lo_i    (sel_lo_w),
        .sel_hi_i    (sel_hi_w),
        .keep_i      (keep_w),
        .a_out_i     (alt_a_out),
        .a_oe_i      (alt_a_oe),
        .b_out_i     (alt_b_out),
        .b_oe_i      (alt_b_oe),
        .c_out_i     (alt_c_out),
        .c_oe_i      (alt_c_oe),
        .pad_out_o   (pad_out),
        .pad_oe_o    (pad_oe),
        .pull_en_o   (pad_pull_en),
        .pull_up_o   (pad_pull_up),
        .eff_lo_o    (pin_sel_lo),
        .eff_hi_o    (pin_sel_hi)
    );
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_in,
    input logic              sleep_force,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_pull_en,
    input logic [NPINS-1:0]  pin_sel_lo,
    input logic [NPINS-1:0]  pin_sel_hi,
    input logic [NPINS-1:0]  pin_level,
    input logic [NPINS-1:0]  dout_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  keep_q
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2
    data_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_DSET)
        |=> ((dout_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R2
    data_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_DCLR)
        |=> ((dout_q & $past(bus_wdata)) == '0));

    // R3
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_DIRCLR)
        |=> ((dir_q & $past(bus_wdata)) == '0));

    // R5
    pull_when_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);

    // R7
    sleep_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_force |-> (((pin_sel_lo | pin_sel_hi) & ~keep_q) == '0));

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (pin_level == $past(pad_in, 2)));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr > A_KEEP) |=> (bus_rdata == '0));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> (bus_rdata == '0));
endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_in      (pad_in),
    .sleep_force (sleep_force),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .pin_sel_lo  (pin_sel_lo),
    .pin_sel_hi  (pin_sel_hi),
    .pin_level   (pin_level),
    .dout_q      (dout_w),
    .dir_q       (dir_w),
    .keep_q      (keep_w)
);

// File: tb/tb_pinbank_ctrl.sv
`timescale 1ns/1ps
module tb_pinbank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0;
    logic        sleep_force = 1'b0;
    logic [31:0] a_out = 32'hA5A5_0F0F, a_oe = 32'hFFFF_0000;
    logic [31:0] b_out = 32'h3C3C_F00F, b_oe = 32'h00FF_00FF;
    logic [31:0] c_out = 32'h6996_1EE1, c_oe = 32'h0F0F_0F0F;
    logic [31:0] pad_out, pad_oe, pull_en, pull_up, sel_lo, sel_hi, level;

    // bench shadow of the programmable state
    logic [31:0] m_dout = '0, m_dir = '0, m_poff = '0, m_lo = '0, m_hi = '0, m_keep = '0;

    int vectors = 0, miscompares = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pinbank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .sleep_force(sleep_force),
        .alt_a_out(a_out), .alt_a_oe(a_oe), .alt_b_out(b_out), .alt_b_oe(b_oe),
        .alt_c_out(c_out), .alt_c_oe(c_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pull_en),
        .pad_pull_up(pull_up), .pin_sel_lo(sel_lo), .pin_sel_hi(sel_hi),
        .pin_level(level)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        case (a)
            5'd1:  m_dout = d;
            5'd2:  m_dout = m_dout | d;
            5'd3:  m_dout = m_dout & ~d;
            5'd4:  m_dir  = d;
            5'd5:  m_dir  = m_dir | d;
            5'd6:  m_dir  = m_dir & ~d;
            5'd7:  m_poff = d;
            5'd8:  m_lo   = d;
            5'd9:  m_hi   = d;
            5'd10: m_keep = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    // expected pad behaviour from the requirements (R4 to R7)
    task automatic check_pins(input string req);
        logic [31:0] e_out, e_oe, e_lo, e_hi;
        for (int i = 0; i < 32; i++) begin
            logic [1:0] c;
            c = (sleep_force && !m_keep[i]) ? 2'b00 : {m_hi[i], m_lo[i]};
            e_lo[i] = c[0]; e_hi[i] = c[1];
            case (c)
                2'b01:   begin e_out[i] = a_out[i]; e_oe[i] = a_oe[i]; end
                2'b10:   begin e_out[i] = b_out[i]; e_oe[i] = b_oe[i]; end
                2'b11:   begin e_out[i] = c_out[i]; e_oe[i] = c_oe[i]; end
                default: begin e_out[i] = m_dout[i]; e_oe[i] = m_dir[i]; end
            endcase
        end
        check({req, " out"}, pad_out, e_out);
        check({req, " oe"}, pad_oe, e_oe);
        check({req, " R5 pull_en"}, pull_en, ~m_poff & ~e_oe);
        check({req, " R6 pull_up"}, pull_up, m_dout);
        check({req, " sel_lo"}, sel_lo, e_lo);
        check({req, " sel_hi"}, sel_hi, e_hi);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_pins("R1");
        for (int a = 1; a <= 10; a++) begin
            rd(a[4:0], r);
            check("R1 reg", r, 32'h0);
        end

        // R2: set / clear data with overlapping masks
        wr(5'd2, 32'hF0F0_1234);  check_pins("R2 set");
        wr(5'd2, 32'h0000_8001);  check_pins("R2 set2");
        wr(5'd3, 32'h3030_0005);  check_pins("R2 clr");
        rd(5'd1, r); check("R2 dout read", r, m_dout);
        rd(5'd2, r); check("R2 set reads zero", r, 32'h0);
        rd(5'd3, r); check("R2 clr reads zero", r, 32'h0);
        wr(5'd1, 32'h1357_9BDF);  rd(5'd1, r); check("R2 full write", r, 32'h1357_9BDF);

        // R3: direction set / clear / readback, GPIO drive
        wr(5'd5, 32'hFF00_FF00);  check_pins("R3 dirset");
        wr(5'd6, 32'h0F00_0F0F);  check_pins("R3 dirclr");
        rd(5'd4, r); check("R3 dir read", r, m_dir);
        wr(5'd4, 32'h5555_AAAA);  rd(5'd4, r); check("R3 dir full", r, 32'h5555_AAAA);

        // R5: pull-off patterns
        wr(5'd7, 32'hCCCC_3333);  check_pins("R5 poff");
        rd(5'd7, r); check("R5 poff read", r, 32'hCCCC_3333);

        // R4: sweep select codes with rotating patterns
        for (int s = 0; s < 16; s++) begin
            logic [31:0] lo, hi;
            lo = 32'h3333_3333 << s;
            hi = 32'h0F0F_0F0F >> s ^ {s[3:0], 28'h0};
            wr(5'd8, lo); wr(5'd9, hi);
            check_pins("R4 sweep");
            wr(5'd2, 32'h1 << s); check_pins("R6 dset in sweep");
        end
        rd(5'd8, r); check("R4 lo read", r, m_lo);
        rd(5'd9, r); check("R4 hi read", r, m_hi);

        // R7 / R8: sleep force across keep patterns
        wr(5'd8, 32'hFFFF_0000); wr(5'd9, 32'hFF00_FF00);
        for (int k = 0; k < 8; k++) begin
            wr(5'd10, 32'h8421_8421 << k);
            @(negedge clk); sleep_force = 1'b1; #1;
            check_pins("R7 forced");
            @(negedge clk); sleep_force = 1'b0; #1;
            check_pins("R8 released");
        end
        wr(5'd10, 32'h0);
        @(negedge clk); sleep_force = 1'b1; #1; check_pins("R7 all forced");
        wr(5'd2, 32'hFFFF_FFFF); check_pins("R7 gpio data during sleep");
        @(negedge clk); sleep_force = 1'b0; #1; check_pins("R8 release all");

        // R9: pad input synchronizer latency and readback
        for (int p = 0; p < 6; p++) begin
            logic [31:0] v;
            v = 32'hDEAD_BEEF ^ (32'h1111_1111 * p);
            @(negedge clk); pad_in = v;
            @(negedge clk); check("R9 one edge old", level, (p == 0) ? 32'h0 : (32'hDEAD_BEEF ^ (32'h1111_1111 * (p - 1))));
            @(negedge clk); check("R9 two edges", level, v);
            rd(5'd0, r); check("R9 level read", r, v);
        end
        wr(5'd0, 32'h0); rd(5'd0, r); check("R9 write ignored", r, pad_in);

        // R10: unmapped addresses
        for (int a = 11; a < 32; a++) begin
            wr(a[4:0], 32'hFFFF_FFFF);
            rd(a[4:0], r); check("R10 unmapped", r, 32'h0);
        end
        check_pins("R10 no side effect");
        @(negedge clk); check("R10 idle rdata", bus_rdata, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule